// File: doc/BRIEF.md
# Three-Phase Sample Realignment Delay

This block realigns paired voltage and current sample streams for three phases, so that a later power stage sees pairs whose relative phase error has been removed. Each phase has one 10-bit calibration word. The word picks which stream of the pair is held back, and by how many whole sample periods. At a 1.024 MHz base rate, one period is about 0.976 µs. The stream that is not held back passes with no latency beyond the common output register.

All three phases share one input valid strobe. Each channel writes into its own circular buffer, and every write pointer advances together. A channel that is delayed reads at the write pointer minus its delay. The calibration words sit behind a small 16-bit register interface. A write outside the legal ranges is refused, and the refusal sets a sticky error flag. After an accepted write, the phase reports its output as not settled until enough new samples have entered the buffer to cover the new delay.

Top module: `phase_align_top`

## Requirements
- R1: After reset, every calibration word reads 0, the error flag is 0, every phase reports settled, and each output pair equals its input pair with no delay.
- R2: A calibration word with bit 9 at 0 and a value d from 0 to 383 delays the current stream of that phase by d valid samples. The voltage stream of that phase is not delayed.
- R3: A calibration word with bit 9 at 1 delays the voltage stream of that phase by the value in bits 5:0, from 0 to 63 valid samples. The current stream of that phase is not delayed.
- R4: A write whose low 10 bits hold 384 to 511 or 576 to 1023 is refused, and the stored word of that phase keeps its previous value.
- R5: A refused write sets an error flag. The flag appears on `cfg_err` and as bit 0 of address 3. Later accepted writes do not clear it; only reset clears it.
- R6: Write bits 15:10 are ignored. Read bits 15:10 are always 0.
- R7: `out_valid` is high exactly one clock after each cycle with `in_valid` high. The output data registers change only on such cycles.
- R8: After an accepted write that sets a delay of d samples for a phase, that phase's `settled` bit is 0 for the first d output samples. It is 1 from sample d+1 onward.
- R9: Addresses 0, 1 and 2 select the calibration words of phases 0, 1 and 2. Read data is registered and appears one clock after the address is presented. Each phase's delay affects only that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0..2 phase words, 3 error flag) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for `cfg_addr` |
| cfg_err | output | 1 | Sticky flag set by a refused write |
| in_valid | input | 1 | Input sample strobe, common to all phases |
| v_in | input | 72 | Voltage samples, phase p at bits [p*24 +: 24] |
| i_in | input | 72 | Current samples, phase p at bits [p*24 +: 24] |
| out_valid | output | 1 | Output sample strobe |
| v_out | output | 72 | Realigned voltage samples |
| i_out | output | 72 | Realigned current samples |
| settled | output | 3 | Per phase: output built only from samples written after the last delay change |

## Verification
The assertions assume that a register write and a valid sample do not fall in the same clock cycle. They also assume that `in_valid` is a clean single-cycle strobe per sample, so the counter-based settle window and the write-pointer step can be stated one cycle at a time. The stimulus follows both rules. Every write is followed by a read-back cycle before samples resume, and samples are driven on falling edges with one strobe per sample. The samples form a counting pattern with a separate offset for each stream, so any output value shows which input sample it came from.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int CAL_W = 10;
  localparam int REG_W = 16;
  localparam int CNT_W = 9;

  typedef logic [CAL_W-1:0] cal_t;

  function automatic logic cal_legal(input cal_t w);
    if (w[9]) return (w[8:6] == 3'b000);
    else      return !(w[8] && w[7]);
  endfunction

  function automatic logic [CNT_W-1:0] cur_delay(input cal_t w);
    return w[9] ? '0 : w[8:0];
  endfunction

  function automatic logic [CNT_W-1:0] volt_delay(input cal_t w);
    return w[9] ? {3'b000, w[5:0]} : '0;
  endfunction
endpackage

// File: rtl/phc_cal_regs.sv
module phc_cal_regs
  import phc_pkg::*;
#(
  parameter int NUM_PH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [NUM_PH-1:0][CAL_W-1:0]  cal_o,
  output logic [NUM_PH-1:0]             upd_o,
  output logic                          err_o
);
  localparam logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(NUM_PH);

  logic [NUM_PH-1:0][CAL_W-1:0] cal_q;
  logic [NUM_PH-1:0]            upd_q;
  logic                         err_q;
  logic                         hit_ph;
  logic                         legal;
  cal_t                         wword;
  logic                         unused_hi;

  assign wword     = wdata_i[CAL_W-1:0];
  assign unused_hi = ^wdata_i[REG_W-1:CAL_W];
  assign legal     = cal_legal(wword);
  assign hit_ph    = (addr_i < ERR_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= '0;
      upd_q <= '0;
      err_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_PH; k++) begin
        upd_q[k] <= 1'b0;
        if (wr_i && hit_ph && legal && (int'(addr_i) == k)) begin
          cal_q[k] <= wword;
          upd_q[k] <= 1'b1;
        end
      end
      if (wr_i && hit_ph && !legal) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (hit_ph) begin
      rdata_o <= {{(REG_W-CAL_W){1'b0}}, cal_q[addr_i]};
    end else if (addr_i == ERR_ADDR) begin
      rdata_o <= {{(REG_W-1){1'b0}}, err_q};
    end else begin
      rdata_o <= '0;
    end
  end

  assign cal_o = cal_q;
  assign upd_o = upd_q;
  assign err_o = err_q;

  // R5: the error flag never drops without reset
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R6: upper read bits stay zero
  p_rd_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rdata_o[REG_W-1:CAL_W] == '0);

  // R4: a refused write leaves every stored word untouched
  p_reject_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hit_ph && !legal) |=> $stable(cal_q));

  // R5: a refused write raises the flag on the next cycle
  p_reject_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hit_ph && !legal) |=> err_q);
endmodule

// File: rtl/phc_delay_line.sv
module phc_delay_line #(
  parameter int DW    = 24,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] wp_i,
  input  logic [AW-1:0] dly_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp;

  assign rp = wp_i - dly_i;

  always_ff @(posedge clk) begin
    if (we_i) mem[wp_i] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= '0;
    end else if (we_i) begin
      if (dly_i == '0) dout_o <= din_i;
      else             dout_o <= mem[rp];
    end
  end
endmodule

// File: rtl/phc_lane.sv
module phc_lane
  import phc_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [AW-1:0] wp_i,
  input  cal_t          cal_i,
  input  logic          upd_i,
  input  logic [DW-1:0] v_i,
  input  logic [DW-1:0] i_i,
  output logic [DW-1:0] v_o,
  output logic [DW-1:0] i_o,
  output logic          settled_o
);
  logic [CNT_W-1:0] cur_d;
  logic [CNT_W-1:0] volt_d;
  logic [CNT_W-1:0] cnt_q;
  logic             settled_q;

  assign cur_d  = cur_delay(cal_i);
  assign volt_d = volt_delay(cal_i);

  phc_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_vline (
    .clk(clk), .rst(rst), .we_i(in_valid_i), .wp_i(wp_i),
    .dly_i(AW'(volt_d)), .din_i(v_i), .dout_o(v_o)
  );

  phc_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_iline (
    .clk(clk), .rst(rst), .we_i(in_valid_i), .wp_i(wp_i),
    .dly_i(AW'(cur_d)), .din_i(i_i), .dout_o(i_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      settled_q <= 1'b1;
    end else begin
      if (upd_i)                         cnt_q <= cur_d | volt_d;
      else if (in_valid_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      if (in_valid_i) settled_q <= (cnt_q == '0) && !upd_i;
    end
  end

  assign settled_o = settled_q;

  // R4: only legal encodings ever reach the lane
  p_cal_legal_r4: assert property (@(posedge clk) disable iff (rst)
    cal_i[9] ? (cal_i[8:6] == 3'b000) : !(cal_i[8] && cal_i[7]));

  // R8: a new delay makes the next output unsettled
  p_settle_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && upd_i) |=> !settled_o);

  // R8: the settle window only shrinks by one per sample
  p_settle_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && in_valid_i && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: the settled flag only moves on sample cycles or reset
  p_settle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(settled_o));
endmodule

// File: rtl/phase_align_top.sv
module phase_align_top
  import phc_pkg::*;
#(
  parameter int NUM_PH = 3,
  parameter int DW     = 24,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [15:0]          cfg_wdata,
  output logic [15:0]          cfg_rdata,
  output logic                 cfg_err,
  input  logic                 in_valid,
  input  logic [NUM_PH*DW-1:0] v_in,
  input  logic [NUM_PH*DW-1:0] i_in,
  output logic                 out_valid,
  output logic [NUM_PH*DW-1:0] v_out,
  output logic [NUM_PH*DW-1:0] i_out,
  output logic [NUM_PH-1:0]    settled
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]                wp_q;
  logic                         ovalid_q;
  logic [NUM_PH-1:0][CAL_W-1:0] cal;
  logic [NUM_PH-1:0]            upd;

  phc_cal_regs #(.NUM_PH(NUM_PH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(cfg_wr), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .cal_o(cal),
    .upd_o(upd), .err_o(cfg_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      ovalid_q <= 1'b0;
    end else begin
      ovalid_q <= in_valid;
      if (in_valid) wp_q <= wp_q + 1'b1;
    end
  end

  assign out_valid = ovalid_q;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_lane
    phc_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst(rst), .in_valid_i(in_valid), .wp_i(wp_q),
      .cal_i(cal[p]), .upd_i(upd[p]),
      .v_i(v_in[p*DW +: DW]), .i_i(i_in[p*DW +: DW]),
      .v_o(v_out[p*DW +: DW]), .i_o(i_out[p*DW +: DW]),
      .settled_o(settled[p])
    );
  end

  // R7: one output strobe per input strobe, one cycle later
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: outputs hold between samples
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(v_out) && $stable(i_out)));

  // R9: the shared buffer pointer moves by one per sample
  p_wp_step_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (wp_q == $past(wp_q) + 1'b1));
endmodule

// File: tb/phase_align_top_tb.sv
module phase_align_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int DW = 24;
  localparam int NV = 12;

  // vector table: phase, written word, expected read-back, expected voltage
  // delay, expected current delay, expected error flag afterwards, accepted
  localparam int          T_PH  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1, 2, 0, 1, 2};
  localparam logic [15:0] T_WR  [NV] = '{16'h0005, 16'h017F, 16'h0201, 16'h023F,
                                         16'h0200, 16'hFC0A, 16'h0180, 16'h01FF,
                                         16'h0240, 16'h03FF, 16'h0000, 16'h0000};
  localparam logic [15:0] T_RD  [NV] = '{16'h0005, 16'h017F, 16'h0201, 16'h023F,
                                         16'h0200, 16'h000A, 16'h023F, 16'h0200,
                                         16'h000A, 16'h023F, 16'h0000, 16'h0000};
  localparam int          T_DV  [NV] = '{0, 0, 1, 63, 0, 0, 63, 0, 0, 63, 0, 0};
  localparam int          T_DI  [NV] = '{5, 383, 0, 0, 0, 10, 0, 0, 10, 0, 0, 0};
  localparam bit          T_ERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam bit          T_OK  [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic cfg_err;
  logic in_valid = 1'b0;
  logic [NP*DW-1:0] v_in = '0;
  logic [NP*DW-1:0] i_in = '0;
  logic out_valid;
  logic [NP*DW-1:0] v_out;
  logic [NP*DW-1:0] i_out;
  logic [NP-1:0] settled;

  int checks = 0;
  int fails = 0;
  int n = 0;
  int dv [NP];
  int di [NP];
  int pend [NP];
  int kafter [NP];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_align_top u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .in_valid(in_valid), .v_in(v_in), .i_in(i_in), .out_valid(out_valid),
    .v_out(v_out), .i_out(i_out), .settled(settled)
  );

  function automatic logic [DW-1:0] vpat(int p, int s);
    return DW'((p << 20) | (s & 32'h7FFFF));
  endfunction
  function automatic logic [DW-1:0] ipat(int p, int s);
    return DW'((p << 20) | 32'h80000 | (s & 32'h7FFFF));
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = 2'(a);
    @(posedge clk);
    #1 d = cfg_rdata;
  endtask

  // one sample into all phases, then check the registered output
  task automatic step(string req);
    @(negedge clk);
    in_valid = 1'b1;
    for (int p = 0; p < NP; p++) begin
      v_in[p*DW +: DW] = vpat(p, n);
      i_in[p*DW +: DW] = ipat(p, n);
    end
    @(posedge clk);
    #1;
    chk("R7", "out_valid", out_valid, 1);
    for (int p = 0; p < NP; p++) begin
      bit se;
      kafter[p]++;
      se = (kafter[p] > pend[p]);
      chk("R8", $sformatf("settled ph%0d", p), settled[p], se);
      if (se) begin
        chk(req, $sformatf("v_out ph%0d", p), v_out[p*DW +: DW], vpat(p, n - dv[p]));
        chk(req, $sformatf("i_out ph%0d", p), i_out[p*DW +: DW], ipat(p, n - di[p]));
      end
    end
    n++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    for (int p = 0; p < NP; p++) begin
      dv[p] = 0; di[p] = 0; pend[p] = 0; kafter[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < NP; a++) begin
      reg_read(a, rd);
      chk("R1", "cal after reset", rd, 0);
    end
    reg_read(3, rd);
    chk("R1", "error reg after reset", rd, 0);
    chk("R1", "cfg_err after reset", cfg_err, 0);
    chk("R1", "settled after reset", settled, 3'b111);
    step("R1");
    step("R1");

    // vector table walk
    for (int t = 0; t < NV; t++) begin
      int p;
      int len;
      p = T_PH[t];
      reg_write(p, T_WR[t]);
      reg_read(p, rd);
      chk(T_OK[t] ? "R6" : "R4", $sformatf("read-back vec %0d", t), rd, T_RD[t]);
      reg_read(3, rd);
      chk("R5", $sformatf("error reg vec %0d", t), rd, T_ERR[t]);
      chk("R5", $sformatf("cfg_err vec %0d", t), cfg_err, T_ERR[t]);
      dv[p] = T_DV[t];
      di[p] = T_DI[t];
      if (T_OK[t]) begin
        pend[p] = (dv[p] > di[p]) ? dv[p] : di[p];
        kafter[p] = 0;
      end
      len = ((dv[p] > di[p]) ? dv[p] : di[p]) + 3;
      for (int s = 0; s < len; s++) step(T_DV[t] != 0 ? "R3" : (T_DI[t] != 0 ? "R2" : "R9"));
    end

    // R9: distinct delays on all three phases at once
    reg_write(0, 16'h0007); dv[0] = 0; di[0] = 7; pend[0] = 7; kafter[0] = 0;
    reg_write(1, 16'h0204); dv[1] = 4; di[1] = 0; pend[1] = 4; kafter[1] = 0;
    reg_write(2, 16'h0002); dv[2] = 0; di[2] = 2; pend[2] = 2; kafter[2] = 0;
    reg_read(0, rd);
    for (int s = 0; s < 12; s++) step("R9");

    // R7: an idle cycle produces no output strobe and holds data
    begin
      logic [NP*DW-1:0] vhold;
      vhold = v_out;
      @(posedge clk);
      #1;
      chk("R7", "out_valid idle", out_valid, 0);
      chk("R7", "v_out held", v_out, vhold);
    end

    // R6: write to the error address is not a phase write
    reg_write(3, 16'h0000);
    reg_read(3, rd);
    chk("R5", "flag survives write to addr 3", rd, 1);

    // R5 / R1: reset clears the flag and the words
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R5", "cfg_err after second reset", cfg_err, 0);
    reg_read(0, rd);
    chk("R1", "ph0 word after second reset", rd, 0);
    for (int p = 0; p < NP; p++) begin
      dv[p] = 0; di[p] = 0; pend[p] = 0; kafter[p] = 0;
    end
    n = 1000;
    step("R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule